// File: doc/BRIEF.md
# Configuration Bitstream Readout Sequencer

This block is the read side of a small configuration store. It streams a stored bitstream into a programmable device that is being configured. An address counter walks a synchronous-read array. The array word is registered and then presented in one of two ways:

- Parallel mode presents one whole byte per qualifying configuration clock.
- Serial mode presents one bit per qualifying configuration clock on data bit 0.

All logic runs on the system clock `clk`. The configuration clock reaches the block as two single-cycle strobes, one external and one internal, and a select input picks which strobe drives the sequence. Three further controls set the counter's behaviour:

- A chip-enable input and an output-enable/reset input force the counter to zero and switch the outputs off.
- A rising edge on the configuration pulse input reloads the counter with the start address of the revision chosen by a 2-bit select.
- A busy flag stalls the walk, but only in parallel mode.

Each bidirectional pin is split into a value output and an enable output, so the high-impedance state can be seen directly.

Top module: `cfg_stream_reader`

## Requirements
- R1: The address advances on a `clk` edge only if all of the following hold: the selected strobe is high, `chip_en_n` is 0, `oe_rst_n` is 1, `cfg_pulse_n` is 1, and busy does not block (R6). In any other case the address holds, unless R2, R3 or R4 applies.
- R2: While `oe_rst_n` is 0, the address and the bit position are forced to 0, `data_oe` is all zero, and `clkout_oe` is 0.
- R3: While `chip_en_n` is 1, the address and the bit position are forced to 0, `data_oe` is all zero, and `clkout_oe` is 0. R2 and R3 take priority over R4.
- R4: A rising edge of `cfg_pulse_n` samples `rev_sel` and loads that revision's start address, with the bit position cleared. The default start addresses are 0, 16, 32 and 48 for revisions 0 to 3. A load wins over an advance in the same cycle.
- R5: Serial mode is `par_mode`=0. Only `data_oe[0]` may be 1, and `data_out[0]` carries the stored byte MSB first. Each qualifying clock moves one bit, and after bit 0 the address moves to the next byte. `busy` is ignored in this mode.
- R6: Parallel mode is `par_mode`=1. All eight `data_oe` bits are 1 when enabled, `data_out` carries the whole byte, and each qualifying clock moves to the next address. While `busy` is 1 the address holds.
- R7: `cclk_src`=0 selects `cclk_ext` and `cclk_src`=1 selects `cclk_int`; the strobe that is not selected has no effect. While enabled, `clkout` follows the selected strobe. While disabled, `clkout` is 0.
- R8: `data_out` reflects the word at the address held before the previous `clk` edge, so it trails the address by one register. While disabled, `data_out` is 0.
- R9: At address DEPTH-1 (default 63) the address holds instead of wrapping. In serial mode the last byte is then repeated bit by bit.
- R10: The word at address a is (29*a + 90) mod 256. After reset, the word at address 0 is 0x5A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cclk_ext | input | 1 | External configuration clock strobe |
| cclk_int | input | 1 | Internal configuration clock strobe |
| cclk_src | input | 1 | Clock source select, 1 = internal |
| chip_en_n | input | 1 | Active-low chip enable; 1 = standby |
| oe_rst_n | input | 1 | Output enable, active-low counter reset |
| cfg_pulse_n | input | 1 | Configuration pulse; rising edge reloads revision |
| busy | input | 1 | Downstream busy, parallel mode only |
| par_mode | input | 1 | 1 = byte-wide, 0 = bit-serial |
| rev_sel | input | 2 | Revision select |
| data_out | output | 8 | Data value |
| data_oe | output | 8 | Per-bit drive enable for data_out |
| clkout | output | 1 | Configuration clock passed downstream |
| clkout_oe | output | 1 | Drive enable for clkout |

## Verification
The enables and `clkout` are combinational from the inputs, so they are due in the same cycle as the stimulus. An address change lands on the `clk` edge that sees the qualifying condition, and the data byte or bit for that address appears one edge later.

The bench drives inputs on the falling edge and samples on the next falling edge. It compares against a reference model that mirrors that one-register lag: the model's output word is taken from its address before each edge, not after. Directed checks after reset and at the address ceiling sample the same way.

// File: rtl/cfg_stream_reader.sv
module cfg_stream_reader #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned REV0  = 0,
  parameter int unsigned REV1  = 16,
  parameter int unsigned REV2  = 32,
  parameter int unsigned REV3  = 48
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cclk_ext,
  input  logic       cclk_int,
  input  logic       cclk_src,
  input  logic       chip_en_n,
  input  logic       oe_rst_n,
  input  logic       cfg_pulse_n,
  input  logic       busy,
  input  logic       par_mode,
  input  logic [1:0] rev_sel,
  output logic [7:0] data_out,
  output logic [7:0] data_oe,
  output logic       clkout,
  output logic       clkout_oe
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  function automatic logic [7:0] word_at(input logic [AW-1:0] a);
    logic [15:0] t;
    t = 16'(a) * 16'd29 + 16'd90;
    return t[7:0];
  endfunction

  logic          tick, active, cf_q, cf_rise, step, byte_done, serial_bit;
  logic [AW-1:0] addr, rev_base;
  logic [2:0]    bit_cnt, bit_q;
  logic [7:0]    byte_q;

  assign tick      = cclk_src ? cclk_int : cclk_ext;
  assign active    = ~chip_en_n & oe_rst_n;
  assign cf_rise   = cfg_pulse_n & ~cf_q;
  assign step      = tick & active & cfg_pulse_n & ~(par_mode & busy);
  assign byte_done = par_mode | (bit_cnt == 3'd7);

  always_comb begin
    case (rev_sel)
      2'd0:    rev_base = AW'(REV0);
      2'd1:    rev_base = AW'(REV1);
      2'd2:    rev_base = AW'(REV2);
      default: rev_base = AW'(REV3);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr    <= '0;
      bit_cnt <= '0;
      bit_q   <= '0;
      byte_q  <= '0;
      cf_q    <= 1'b1;
    end else begin
      cf_q   <= cfg_pulse_n;
      byte_q <= word_at(addr);
      bit_q  <= bit_cnt;
      if (!active) begin
        addr    <= '0;
        bit_cnt <= '0;
      end else if (cf_rise) begin
        addr    <= rev_base;
        bit_cnt <= '0;
      end else if (step) begin
        bit_cnt <= par_mode ? 3'd0 : bit_cnt + 3'd1;
        if (byte_done && addr != LAST) addr <= addr + 1'b1;
      end
    end
  end

  assign serial_bit = byte_q[3'd7 - bit_q];
  assign data_out   = !active ? 8'h00 : (par_mode ? byte_q : {7'b0, serial_bit});
  assign data_oe    = {{7{active & par_mode}}, active};
  assign clkout     = active & tick;
  assign clkout_oe  = active;

  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !step && !cf_rise) |=> $stable(addr)); // R1
  AST_OE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_rst_n |=> (addr == '0 && bit_cnt == 3'd0)); // R2
  AST_STANDBY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    chip_en_n |-> (data_oe == 8'h00 && !clkout_oe)); // R3
  AST_REV_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cf_rise) |=> addr == $past(rev_base)); // R4
  AST_SERIAL_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    !par_mode |-> data_oe[7:1] == 7'b0); // R5
  AST_BUSY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (active && par_mode && busy && !cf_rise) |=> $stable(addr)); // R6
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && addr == LAST && !cf_rise) |=> addr == LAST); // R9
endmodule

// File: tb/cfg_stream_reader_bench.sv
`timescale 1ns/1ps
module cfg_stream_reader_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cclk_ext = 1'b0, cclk_int = 1'b0, cclk_src = 1'b0;
  logic chip_en_n = 1'b1, oe_rst_n = 1'b1, cfg_pulse_n = 1'b1, busy = 1'b0, par_mode = 1'b1;
  logic [1:0] rev_sel = 2'd0;
  logic [7:0] data_out, data_oe;
  logic clkout, clkout_oe;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cfg_stream_reader u_cfg_stream_reader (
    .clk(clk), .rst_n(rst_n), .cclk_ext(cclk_ext), .cclk_int(cclk_int), .cclk_src(cclk_src),
    .chip_en_n(chip_en_n), .oe_rst_n(oe_rst_n), .cfg_pulse_n(cfg_pulse_n), .busy(busy),
    .par_mode(par_mode), .rev_sel(rev_sel), .data_out(data_out), .data_oe(data_oe),
    .clkout(clkout), .clkout_oe(clkout_oe));

  // reference model state, built from the requirements
  logic [5:0] m_addr = '0;
  logic [2:0] m_cnt = '0, m_bit = '0;
  logic [7:0] m_byte = '0;
  logic       m_cf = 1'b1;

  function automatic logic [7:0] ref_word(input logic [5:0] a); // R10
    logic [15:0] t;
    t = 16'(a) * 16'd29 + 16'd90;
    return t[7:0];
  endfunction

  function automatic string req_name(input logic [3:0] n);
    case (n)
      4'd1: return "R1";  4'd2: return "R2";  4'd3: return "R3";
      4'd4: return "R4";  4'd5: return "R5";  4'd6: return "R6";
      4'd7: return "R7";  4'd8: return "R8";  4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic model_edge();
    logic act, tick, rise, stp;
    act  = !chip_en_n && oe_rst_n;
    tick = cclk_src ? cclk_int : cclk_ext;
    rise = cfg_pulse_n && !m_cf;
    stp  = tick && act && cfg_pulse_n && !(par_mode && busy);
    m_byte = ref_word(m_addr);
    m_bit  = m_cnt;
    m_cf   = cfg_pulse_n;
    if (!act) begin
      m_addr = '0; m_cnt = '0;
    end else if (rise) begin
      case (rev_sel)
        2'd0: m_addr = 6'd0;  2'd1: m_addr = 6'd16;
        2'd2: m_addr = 6'd32; default: m_addr = 6'd48;
      endcase
      m_cnt = '0;
    end else if (stp) begin
      if ((par_mode || m_cnt == 3'd7) && m_addr != 6'd63) m_addr = m_addr + 6'd1;
      m_cnt = par_mode ? 3'd0 : m_cnt + 3'd1;
    end
  endtask

  task automatic compare(input string tag);
    logic act, tick;
    string rq;
    logic [7:0] exp_d, exp_oe;
    act  = !chip_en_n && oe_rst_n;
    tick = cclk_src ? cclk_int : cclk_ext;
    rq   = chip_en_n ? "R3" : (!oe_rst_n ? "R2" : tag);
    exp_d  = !act ? 8'h00 : (par_mode ? m_byte : {7'b0, m_byte[3'd7 - m_bit]});
    exp_oe = {{7{act && par_mode}}, act};
    chk(rq, "data_out", data_out, exp_d);
    chk(rq, "data_oe", data_oe, exp_oe);
    chk("R7", "clkout", {6'b0, clkout_oe, clkout}, {6'b0, act, act && tick});
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  // fields: ce_n oe cf busy par src ext int rev[1:0] tag[3:0] reps[7:0]
  localparam int NV = 14;
  localparam logic [21:0] VEC [NV] = '{
    {1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,2'd0,4'd3,8'd3},   // R3 standby
    {1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,2'd0,4'd6,8'd6},   // R6 parallel walk
    {1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,2'd0,4'd6,8'd4},   // R6 busy stall
    {1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,2'd0,4'd7,8'd3},   // R7 ext ignored
    {1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,2'd0,4'd7,8'd8},   // R7 internal source
    {1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,2'd2,4'd1,8'd2},   // R1 pulse low holds
    {1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,2'd2,4'd4,8'd5},   // R4 load rev 2
    {1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,2'd2,4'd5,8'd20},  // R5 serial, busy ignored
    {1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,2'd2,4'd2,8'd2},   // R2 counter reset
    {1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd2,4'd1,8'd3},   // R1 no strobe
    {1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,2'd2,4'd5,8'd10},  // R5 serial from 0
    {1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,2'd3,4'd1,8'd2},   // R1 pulse low
    {1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,2'd3,4'd9,8'd24},  // R9 parallel ceiling
    {1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,2'd1,4'd3,8'd3}    // R3 pulse in standby
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R3", "data_oe in reset", data_oe, 8'h00);
    chk("R3", "clkout_oe in reset", {7'b0, clkout_oe}, 8'h00);
    rst_n = 1'b1;
    chip_en_n = 1'b0;
    cyc("R8");
    chk("R10", "word 0 after reset", data_out, 8'h5A);
    cyc("R8");

    for (int v = 0; v < NV; v++) begin
      {chip_en_n, oe_rst_n, cfg_pulse_n, busy, par_mode, cclk_src, cclk_ext, cclk_int, rev_sel} = VEC[v][21:12];
      for (int r = 0; r < int'(VEC[v][7:0]); r++) cyc(req_name(VEC[v][11:8]));
    end

    // R9: serial walk past the ceiling from revision 3
    {chip_en_n, oe_rst_n, busy, par_mode, cclk_src, cclk_ext, rev_sel} = {1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,2'd3};
    cfg_pulse_n = 1'b0; cyc("R4");
    cfg_pulse_n = 1'b1;
    for (int r = 0; r < 200; r++) cyc("R9");

    // R4 and R8: load revision 1 in parallel, then one step
    par_mode = 1'b1; cclk_ext = 1'b0; rev_sel = 2'd1;
    cfg_pulse_n = 1'b0; cyc("R4");
    cfg_pulse_n = 1'b1; cyc("R4");
    cyc("R8");
    chk("R4", "rev1 start word", data_out, ref_word(6'd16));
    cclk_ext = 1'b1; cyc("R8");
    cclk_ext = 1'b0; cyc("R8");
    chk("R8", "word after one step", data_out, ref_word(6'd17));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule